// File: doc/BRIEF.md
# Zonal 8x8 Two-Dimensional DCT

This block turns an 8x8 block of signed 8-bit image samples into 64 transform coefficients. It uses the row-column method. A first one-dimensional pass runs along each row of samples. Its results are written back into a single 64-word working buffer. A second one-dimensional pass then runs down each column of that buffer. In both passes each line of eight values first goes through a mirror-pair add/subtract stage. The four sums feed the even-index processing elements and the four differences feed the odd-index ones. Eight processing elements then form the inner products bit-serially by distributed arithmetic. Each element looks up a 16-entry table of pre-added basis weights and accumulates the table word with shift-and-add. On the sign bit it subtracts instead of adding.

Two block-level settings select the work done. The zone setting limits the result to the top-left KxK coefficients. Processing elements whose index is K or above hold a zero accumulator, and every coefficient outside the zone is delivered as zero. The precision setting rounds each final coefficient to its upper 8 bits. The two settings together give sixteen configurations. They are captured together with the first sample of a block, so the stream never pauses to change them. Samples enter and coefficients leave one per handshake in raster order, with valid/ready flow control on both sides.

Top module: `zonal_dct8x8`

## Requirements
- R1: While reset is asserted and in the first cycle after it, in_ready is 1 and out_valid is 0.
- R2: A block is 64 accepted samples in raster order, sample (j,i) at position 8*j+i with j the row. After them the block presents 64 coefficients in raster order, coefficient (u,v) at position 8*u+v with u the vertical frequency. After the 64th output handshake in_ready is 1 again.
- R3: At full precision (prec_lo=0), coefficient (u,v) inside the zone equals floor(sum over j of C[u][j]*r(j,v) / 128), where r(j,v) = floor(sum over i of C[v][i]*x(j,i) / 128). Here C[k][n] = round(64*c_k*cos((2n+1)*k*pi/16)), with c_0 = 1/sqrt(2) and c_k = 1 otherwise. The coefficient is given as 12-bit two's complement. A block of all 10s gives 78 at position 0 and 0 elsewhere.
- R4: zone_sel = z selects K = z+1. Every coefficient with u >= K or v >= K is 0.
- R5: With prec_lo=1 each coefficient is the R3 value plus 8, with bits 3..0 then cleared. A block of all 10s gives 80 at position 0.
- R6: zone_sel and prec_lo are taken with the first accepted sample of a block. Changes after that have no effect on that block's coefficients.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_coef hold. No coefficient is lost or repeated.
- R8: in_ready is 0 from the cycle after the 64th accepted sample until the last coefficient of the block is taken. in_ready and out_valid are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block is collecting samples |
| in_sample | input | 8 | Signed sample, raster order |
| zone_sel | input | 3 | Zone size minus one |
| prec_lo | input | 1 | 1 selects rounded 8-significant-bit output |
| out_valid | output | 1 | Coefficient offered |
| out_ready | input | 1 | Downstream accepts coefficient |
| out_coef | output | 12 | Signed coefficient, raster order |

## Verification
A fault in the sequencer (line index, pass flag or bit position) corrupts whole rows or columns of the block. Such a fault shows as wrong coefficients in the first block after it, about 240 cycles after the last sample. A fault in a processing element's table or sign handling shows only in the coefficient index that element serves. For that reason the stimulus includes random, extreme and constant blocks at several zones, so that every element is used with both signs. A wrong mode latch or handshake counter shows at once: nonzero values outside the zone, low bits set in rounded mode, or a data change during a stall.

// File: rtl/zdct_pkg.sv
package zdct_pkg;

    typedef enum logic [2:0] {
        ST_LOAD  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CALC  = 3'd2,
        ST_STORE = 3'd3,
        ST_OUT   = 3'd4
    } zdct_state_e;

    // basis weights scaled by 128
    localparam int WA = 45;
    localparam int WB = 59;
    localparam int WC = 24;
    localparam int WD = 63;
    localparam int WE = 53;
    localparam int WF = 36;
    localparam int WG = 12;

    // weight applied by element pe to folded operand tap (0..3)
    function automatic int basis_weight(input int pe, input int tap);
        case (pe)
            0: return WA;
            1: case (tap) 0: return WD;  1: return WE;  2: return WF;  default: return WG;  endcase
            2: case (tap) 0: return WB;  1: return WC;  2: return -WC; default: return -WB; endcase
            3: case (tap) 0: return WE;  1: return -WG; 2: return -WD; default: return -WF; endcase
            4: case (tap) 0: return WA;  1: return -WA; 2: return -WA; default: return WA;  endcase
            5: case (tap) 0: return WF;  1: return -WD; 2: return WG;  default: return WE;  endcase
            6: case (tap) 0: return WC;  1: return -WB; 2: return WB;  default: return -WC; endcase
            default: case (tap) 0: return WG; 1: return -WF; 2: return WE; default: return -WD; endcase
        endcase
    endfunction

    // table word: sum of the weights whose tap bit is set in addr
    function automatic int rom_word(input int pe, input int addr);
        int total;
        total = 0;
        for (int t = 0; t < 4; t++) begin
            if (((addr >> t) & 1) != 0) total += basis_weight(pe, t);
        end
        return total;
    endfunction

endpackage

// File: rtl/zdct_butterfly.sv
module zdct_butterfly #(
    parameter int DW = 12,
    parameter int OW = 13
) (
    input  logic signed [DW-1:0] x_i   [8],
    output logic signed [OW-1:0] sum_o [4],
    output logic signed [OW-1:0] dif_o [4]
);
    localparam int EXT = OW - DW;

    for (genvar i = 0; i < 4; i++) begin : g_pair
        logic signed [OW-1:0] near_v;
        logic signed [OW-1:0] far_v;
        assign near_v   = {{EXT{x_i[i][DW-1]}}, x_i[i]};
        assign far_v    = {{EXT{x_i[7-i][DW-1]}}, x_i[7-i]};
        assign sum_o[i] = near_v + far_v;
        assign dif_o[i] = near_v - far_v;
    end
endmodule

// File: rtl/zdct_da_pe.sv
module zdct_da_pe
    import zdct_pkg::*;
#(
    parameter int PE_IDX = 0,
    parameter int ROM_W  = 10,
    parameter int ACC_W  = 25,
    parameter int POS_W  = 4,
    parameter int FRAC   = 7,
    parameter int RES_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    step,
    input  logic                    active,
    input  logic                    last,
    input  logic [POS_W-1:0]        bit_pos,
    input  logic [3:0]              addr,
    output logic signed [RES_W-1:0] res_o
);
    localparam int EXT = ACC_W - ROM_W;

    logic signed [ROM_W-1:0] rom [16];

    for (genvar a = 0; a < 16; a++) begin : g_rom
        assign rom[a] = ROM_W'(rom_word(PE_IDX, a));
    end

    logic signed [ROM_W-1:0] word;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        word  = rom[addr];
        term  = {{EXT{word[ROM_W-1]}}, word} <<< bit_pos;
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (step && active) begin
            acc_d = last ? (acc_q - term) : (acc_q + term);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign res_o = acc_q[FRAC +: RES_W];
endmodule

// File: rtl/zdct_ctrl.sv
module zdct_ctrl
    import zdct_pkg::*;
#(
    parameter int ZONE_W = 3,
    parameter int NB     = 13,
    parameter int POS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic [ZONE_W-1:0] zone_i,
    input  logic              prec_i,
    output logic              in_ready,
    output logic              out_valid,
    output zdct_state_e       state_o,
    output logic [2*ZONE_W-1:0] cnt_o,
    output logic [ZONE_W-1:0] line_o,
    output logic              pass_o,
    output logic [POS_W-1:0]  pos_o,
    output logic [ZONE_W-1:0] zone_o,
    output logic              prec_o
);
    localparam int LN_W = ZONE_W;
    localparam int CNT_W = 2 * ZONE_W;
    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [LN_W-1:0]  LINE_LAST = '1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(NB - 1);

    typedef struct packed {
        zdct_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [LN_W-1:0]   line;
        logic              pass;
        logic [POS_W-1:0]  pos;
        logic [ZONE_W-1:0] zone;
        logic              prec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_LOAD: begin
                if (in_valid) begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.zone = zone_i;
                        ctl_d.prec = prec_i;
                    end
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == CNT_LAST) begin
                        ctl_d.st   = ST_FETCH;
                        ctl_d.pass = 1'b0;
                        ctl_d.line = '0;
                    end
                end
            end
            ST_FETCH: begin
                ctl_d.st  = ST_CALC;
                ctl_d.pos = '0;
            end
            ST_CALC: begin
                ctl_d.pos = ctl_q.pos + 1'b1;
                if (ctl_q.pos == POS_LAST) ctl_d.st = ST_STORE;
            end
            ST_STORE: begin
                ctl_d.line = ctl_q.line + 1'b1;
                ctl_d.st   = ST_FETCH;
                if (ctl_q.line == LINE_LAST) begin
                    if (!ctl_q.pass) begin
                        ctl_d.pass = 1'b1;
                    end else begin
                        ctl_d.st  = ST_OUT;
                        ctl_d.cnt = '0;
                    end
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == CNT_LAST) ctl_d.st = ST_LOAD;
                end
            end
            default: ctl_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_LOAD;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready  = (ctl_q.st == ST_LOAD);
    assign out_valid = (ctl_q.st == ST_OUT);
    assign state_o   = ctl_q.st;
    assign cnt_o     = ctl_q.cnt;
    assign line_o    = ctl_q.line;
    assign pass_o    = ctl_q.pass;
    assign pos_o     = ctl_q.pos;
    assign zone_o    = ctl_q.zone;
    assign prec_o    = ctl_q.prec;
endmodule

// File: rtl/zonal_dct8x8.sv
module zonal_dct8x8
    import zdct_pkg::*;
#(
    parameter int IN_W      = 8,
    parameter int OUT_W     = 12,
    parameter int ZONE_W    = 3,
    parameter int FRAC      = 7,
    parameter int KEEP_BITS = 8,
    parameter int ROM_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_sample,
    input  logic [ZONE_W-1:0] zone_sel,
    input  logic             prec_lo,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_coef
);
    localparam int N     = 1 << ZONE_W;
    localparam int LN_W  = ZONE_W;
    localparam int CNT_W = 2 * ZONE_W;
    localparam int WORDS = N * N;
    localparam int BUF_W = OUT_W;
    localparam int BF_W  = BUF_W + 1;
    localparam int NB    = BF_W;
    localparam int POS_W = $clog2(NB);
    localparam int ACC_W = BF_W + ROM_W + 2;
    localparam int DROP  = OUT_W - KEEP_BITS;
    localparam logic signed [BUF_W-1:0] HALF = BUF_W'(1 << (DROP - 1));

    zdct_state_e       st;
    logic [CNT_W-1:0]  cnt_q;
    logic [LN_W-1:0]   line_q;
    logic              pass_q;
    logic [POS_W-1:0]  pos_q;
    logic [ZONE_W-1:0] zone_q;
    logic              prec_q;

    zdct_ctrl #(.ZONE_W(ZONE_W), .NB(NB), .POS_W(POS_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .zone_i    (zone_sel),
        .prec_i    (prec_lo),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .state_o   (st),
        .cnt_o     (cnt_q),
        .line_o    (line_q),
        .pass_o    (pass_q),
        .pos_o     (pos_q),
        .zone_o    (zone_q),
        .prec_o    (prec_q)
    );

    // working buffer shared by both passes
    logic signed [BUF_W-1:0] mem_d [WORDS];
    logic signed [BUF_W-1:0] mem_q [WORDS];

    // line gathered from the buffer: a row in pass 0, a column in pass 1
    logic signed [BUF_W-1:0] line_x [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            line_x[i] = pass_q ? mem_q[{LN_W'(i), line_q}] : mem_q[{line_q, LN_W'(i)}];
        end
    end

    logic signed [BF_W-1:0] bf_sum [4];
    logic signed [BF_W-1:0] bf_dif [4];

    zdct_butterfly #(.DW(BUF_W), .OW(BF_W)) u_bfly (
        .x_i   (line_x),
        .sum_o (bf_sum),
        .dif_o (bf_dif)
    );

    logic signed [BF_W-1:0] sum_d [4];
    logic signed [BF_W-1:0] sum_q [4];
    logic signed [BF_W-1:0] dif_d [4];
    logic signed [BF_W-1:0] dif_q [4];

    always_comb begin
        sum_d = sum_q;
        dif_d = dif_q;
        if (st == ST_FETCH) begin
            sum_d = bf_sum;
            dif_d = bf_dif;
        end
    end

    logic signed [BUF_W-1:0] pe_res [N];
    logic                    on_last;

    assign on_last = (pos_q == POS_W'(NB - 1));

    for (genvar k = 0; k < N; k++) begin : g_pe
        logic [3:0] tap_bits;
        for (genvar t = 0; t < 4; t++) begin : g_tap
            if (k % 2 == 0) begin : g_even
                assign tap_bits[t] = sum_q[t][pos_q];
            end else begin : g_odd
                assign tap_bits[t] = dif_q[t][pos_q];
            end
        end
        zdct_da_pe #(
            .PE_IDX (k),
            .ROM_W  (ROM_W),
            .ACC_W  (ACC_W),
            .POS_W  (POS_W),
            .FRAC   (FRAC),
            .RES_W  (BUF_W)
        ) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (st == ST_FETCH),
            .step    (st == ST_CALC),
            .active  (LN_W'(k) <= zone_q),
            .last    (on_last),
            .bit_pos (pos_q),
            .addr    (tap_bits),
            .res_o   (pe_res[k])
        );
    end

    // final rounding applies to the second pass only
    logic signed [BUF_W-1:0] wr_val [N];

    always_comb begin
        for (int k = 0; k < N; k++) begin
            wr_val[k] = pe_res[k];
            if (pass_q && prec_q) begin
                wr_val[k] = pe_res[k] + HALF;
                wr_val[k][DROP-1:0] = '0;
            end
        end
    end

    always_comb begin
        mem_d = mem_q;
        if (st == ST_LOAD && in_valid) begin
            mem_d[cnt_q] = {{(BUF_W-IN_W){in_sample[IN_W-1]}}, in_sample};
        end
        if (st == ST_STORE) begin
            for (int k = 0; k < N; k++) begin
                if (pass_q) mem_d[{LN_W'(k), line_q}] = wr_val[k];
                else        mem_d[{line_q, LN_W'(k)}] = wr_val[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
            for (int t = 0; t < 4; t++) begin
                sum_q[t] <= '0;
                dif_q[t] <= '0;
            end
        end else begin
            mem_q <= mem_d;
            sum_q <= sum_d;
            dif_q <= dif_d;
        end
    end

    assign out_coef = mem_q[cnt_q];
endmodule

// File: rtl/zdct_checker.sv
module zdct_checker #(
    parameter int ZONE_W = 3,
    parameter int OUT_W  = 12,
    parameter int DROP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_coef,
    input logic [ZONE_W-1:0] zone_q,
    input logic              prec_q,
    input logic [2*ZONE_W-1:0] out_idx
);
    // R4
    zone_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ((out_idx[2*ZONE_W-1:ZONE_W] > zone_q) || (out_idx[ZONE_W-1:0] > zone_q))
        |-> out_coef == '0);

    // R5
    prec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && prec_q |-> out_coef[DROP-1:0] == '0);

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_coef));

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> $stable(zone_q) && $stable(prec_q));

    // R2
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && (out_idx == '1) |=> in_ready);
endmodule

bind zonal_dct8x8 zdct_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_coef  (out_coef),
    .zone_q    (zone_q),
    .prec_q    (prec_q),
    .out_idx   (cnt_q)
);

// File: tb/zonal_dct8x8_test.sv
module zonal_dct8x8_test;
    localparam int CLK_NS = 10;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_sample = '0;
    logic [2:0]  zone_sel = '0;
    logic        prec_lo = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [11:0] out_coef;

    always #(CLK_NS/2) clk = ~clk;

    zonal_dct8x8 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .zone_sel(zone_sel), .prec_lo(prec_lo),
        .out_valid(out_valid), .out_ready(out_ready), .out_coef(out_coef)
    );

    int    checks = 0;
    int    errors = 0;
    int    cm [8][8];
    int    blk [64];
    int    exp_q [$];
    int    got [64];
    int    recv = 0;
    int    blk_zone = 7;
    bit    blk_prec = 0;
    string tag_force = "";
    int    held = 0;
    bit    hold_pend = 0;
    bit    done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic build_expected();
        int r [8][8];
        int k;
        int s;
        int y;
        k = blk_zone + 1;
        exp_q.delete();
        for (int j = 0; j < 8; j++) begin
            for (int v = 0; v < 8; v++) begin
                s = 0;
                for (int i = 0; i < 8; i++) s += cm[v][i] * blk[j*8+i];
                r[j][v] = (v < k) ? (s >>> 7) : 0;
            end
        end
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                y = 0;
                if (u < k && v < k) begin
                    s = 0;
                    for (int j = 0; j < 8; j++) s += cm[u][j] * r[j][v];
                    y = s >>> 7;
                    if (blk_prec) y = ((y + 8) >>> 4) * 16;
                end
                exp_q.push_back(y);
            end
        end
    endtask

    // monitor: every falling edge
    always @(negedge clk) begin : mon
        int e;
        int a;
        int u;
        int v;
        string tg;
        if (rst_n && !done) begin
            check(!(in_ready && out_valid), "R8", int'(in_ready), 0);
            if (hold_pend) begin
                check(out_valid && (int'(out_coef) == held), "R7", int'(out_coef), held);
            end
            hold_pend = out_valid && !out_ready;
            held = int'(out_coef);
            if (out_valid && out_ready) begin
                a = int'($signed(out_coef));
                if (exp_q.size() == 0) begin
                    check(0, "R2", a, 0);
                end else begin
                    e = exp_q.pop_front();
                    u = recv / 8;
                    v = recv % 8;
                    if (tag_force != "")                   tg = tag_force;
                    else if (u > blk_zone || v > blk_zone) tg = "R4";
                    else if (blk_prec)                     tg = "R5";
                    else                                   tg = "R3";
                    check(a == e, tg, a, e);
                    if (recv < 64) got[recv] = a;
                    recv++;
                end
            end
        end
    end

    task automatic feed(input int z, input bit p, input int az, input bit ap, input int gap_pct);
        int i;
        bit took;
        i = 0;
        zone_sel = 3'(z);
        prec_lo = p;
        while (i < 64) begin
            in_valid = ($urandom_range(99) >= gap_pct);
            in_sample = 8'(blk[i]);
            @(negedge clk);
            took = in_valid && in_ready;
            @(posedge clk);
            #1;
            if (took) begin
                if (i == 0) begin
                    zone_sel = 3'(az);
                    prec_lo = ap;
                end
                i++;
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b0, "R8", int'(in_ready), 0);
    endtask

    task automatic drain(input int rdy_pct);
        while (recv < 64) begin
            out_ready = ($urandom_range(99) < rdy_pct);
            @(posedge clk);
            #1;
        end
        out_ready = 1'b0;
    endtask

    task automatic run_block(input int z, input bit p, input int az, input bit ap,
                             input int gap_pct, input int rdy_pct);
        blk_zone = z;
        blk_prec = p;
        build_expected();
        recv = 0;
        fork
            feed(z, p, az, ap, gap_pct);
            drain(rdy_pct);
        join
        @(negedge clk);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        check(in_ready == 1'b1, "R2", int'(in_ready), 1);
        @(posedge clk);
        #1;
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        real ck;
        for (int k = 0; k < 8; k++) begin
            ck = (k == 0) ? (1.0 / $sqrt(2.0)) : 1.0;
            for (int n = 0; n < 8; n++) begin
                cm[k][n] = int'(64.0 * ck * $cos(real'((2*n+1)*k) * PI / 16.0));
            end
        end

        repeat (3) @(posedge clk);
        #1;
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", int'({in_ready, out_valid}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", int'({in_ready, out_valid}), 2);
        @(posedge clk);
        #1;

        // constant block, full precision
        for (int i = 0; i < 64; i++) blk[i] = 10;
        run_block(7, 0, 3, 1, 0, 100);
        check(got[0] == 78, "R3", got[0], 78);
        check(got[9] == 0, "R3", got[9], 0);

        // constant block, rounded
        run_block(7, 1, 0, 0, 0, 100);
        check(got[0] == 80, "R5", got[0], 80);

        // random blocks with gaps and back-pressure
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        run_block(7, 0, 2, 1, 30, 60);
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        run_block(3, 1, 7, 0, 20, 50);
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        run_block(0, 0, 5, 1, 10, 70);
        check(got[1] == 0 && got[8] == 0, "R4", got[1] + got[8], 0);

        // extreme magnitude checkerboard, heavy back-pressure
        for (int i = 0; i < 64; i++) blk[i] = (((i / 8) + (i % 8)) % 2 == 1) ? -128 : 127;
        run_block(7, 0, 1, 1, 0, 20);

        // all minimum, partial zone, rounded
        for (int i = 0; i < 64; i++) blk[i] = -128;
        run_block(5, 1, 6, 0, 40, 40);

        // mode change after first sample must not affect the block
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        tag_force = "R6";
        run_block(1, 0, 7, 1, 25, 80);
        check(got[18] == 0 && got[63] == 0, "R6", got[18] + got[63], 0);
        tag_force = "";

        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        run_block(6, 1, 2, 0, 15, 90);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule